// File: doc/BRIEF.md
# Clock Unit Control and Status Register

This block is one byte of control and status state inside a microcontroller clock unit. Software writes it to power the PLL up or down and to enable two auxiliary clock prescalers. Hardware uses it to record that a power-on event has occurred. Each bit has its own write rule, and some of those rules depend on hardware conditions.

A write of 0 to the PLL power-down bit only lands while the PLL reports a stable clock. The power-on flag can be set by hardware but only cleared by software. Each auxiliary clock enable is combined with main-clock stability into a registered run signal. The block also provides a permit that tells the neighbouring PLL mode field whether a write is allowed at the moment. The bits are packed into one readback byte, and the unused positions return zero.

Top module: `clk_ctl_status`

## Requirements
- R1: After reset, `pll_pd` is 1, both auxiliary enables are 0, `aux_run` is 0 and the power-on flag is 0, so `rd_data` reads 0x01.
- R2: A write with bit 0 set sets the PLL power-down bit in any condition. A write with bit 0 clear clears it only if `pll_stable` is 1 in that cycle; otherwise that write leaves the bit unchanged.
- R3: `aux_run[k]` is registered: after each clock edge it equals the enable bit k after that edge ANDed with `main_stable` sampled at that edge. It is 0 whenever the main clock was not stable at the last edge.
- R4: Each write loads auxiliary clock 1's enable from bit 1 and auxiliary clock 2's enable from bit 2, with no condition.
- R5: A cycle with `por_det` high sets the power-on flag (bit 3) at that clock edge.
- R6: A write with bit 3 clear clears the power-on flag. A write with bit 3 set leaves it unchanged, so software can never set it.
- R7: When `por_det` is high and a clearing write arrive in the same cycle, the flag ends up 1.
- R8: `mode_wr_ok` is 1 exactly when `sysclk_from_pll` is 0.
- R9: Readback layout: bit 0 is PLL power-down, bit 1 is the aux 1 enable, bit 2 is the aux 2 enable, bit 3 is the power-on flag, and bits 7..4 always read 0, whatever was written to them.
- R10: `pll_pd` always equals the stored PLL power-down bit, as it reads back in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for this register |
| wr_data | input | 8 | Write data byte |
| pll_stable | input | 1 | PLL output reported stable |
| main_stable | input | 1 | Main oscillator reported stable |
| por_det | input | 1 | Power-on detect pulse |
| sysclk_from_pll | input | 1 | System clock currently sourced from the PLL |
| rd_data | output | 8 | Register readback |
| pll_pd | output | 1 | PLL power-down control |
| aux_run | output | 2 | Effective run signals for auxiliary clocks 1 and 2 |
| mode_wr_ok | output | 1 | Permit for writes to the PLL mode field |

## Verification
The hardest situation to reach is a cycle in which several rules meet at once. One case is a power-on pulse arriving together with a clearing write. Another is a write of 0 to the PLL bit landing exactly while `pll_stable` is low, followed by a second write after it rises. The stimulus sets up each of these collisions deliberately, cycle by cycle. It also toggles `main_stable` while the enables stay set, so the one-edge lag of `aux_run` shows up in both directions.

// File: rtl/ccsr_pkg.sv
package ccsr_pkg;
    localparam int unsigned REG_W    = 8;
    localparam int unsigned NUM_AUX  = 2;
    localparam int unsigned PLL_POS  = 0;
    localparam int unsigned AUX_BASE = 1;
    localparam int unsigned FLAG_POS = AUX_BASE + NUM_AUX;
endpackage

// File: rtl/ccsr_pll_bit.sv
module ccsr_pll_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_bit,
    input  logic pll_stable,
    output logic pll_off
);
    typedef struct packed {
        logic off;
    } pll_st_t;

    pll_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            if (wr_bit)          st_d.off = 1'b1;
            else if (pll_stable) st_d.off = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{off: 1'b1};
        else        st_q <= st_d;
    end

    assign pll_off = st_q.off;

    a_r2_hold_unstable: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_bit && !pll_stable && pll_off) |=> pll_off);
    a_r2_set_always: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_bit) |=> pll_off);
endmodule

// File: rtl/ccsr_aux_gate.sv
module ccsr_aux_gate #(
    parameter int unsigned N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [N-1:0] wr_bits,
    input  logic         main_stable,
    output logic [N-1:0] en,
    output logic [N-1:0] run
);
    typedef struct packed {
        logic en;
        logic run;
    } aux_st_t;

    for (genvar k = 0; k < N; k++) begin : g_ch
        aux_st_t st_d, st_q;

        always_comb begin
            st_d = st_q;
            if (wr_en) st_d.en = wr_bits[k];
            st_d.run = st_d.en & main_stable;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st_q <= '0;
            else        st_q <= st_d;
        end

        assign en[k]  = st_q.en;
        assign run[k] = st_q.run;

        a_r3_run_needs_stable: assert property (@(posedge clk) disable iff (!rst_n)
            run[k] |-> $past(main_stable));
        a_r3_stop_unstable: assert property (@(posedge clk) disable iff (!rst_n)
            !main_stable |=> !run[k]);
    end
endmodule

// File: rtl/ccsr_por_flag.sv
module ccsr_por_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic por_det,
    input  logic wr_en,
    input  logic wr_bit,
    output logic flag
);
    typedef struct packed {
        logic flag;
    } por_st_t;

    por_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en && !wr_bit) st_d.flag = 1'b0;
        if (por_det)          st_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag = st_q.flag;

    a_r7_detect_wins: assert property (@(posedge clk) disable iff (!rst_n)
        por_det |=> flag);
    a_r6_no_sw_set: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag && !por_det) |=> !flag);
endmodule

// File: rtl/clk_ctl_status.sv
module clk_ctl_status
    import ccsr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             pll_stable,
    input  logic             main_stable,
    input  logic             por_det,
    input  logic             sysclk_from_pll,
    output logic [REG_W-1:0] rd_data,
    output logic             pll_pd,
    output logic [NUM_AUX-1:0] aux_run,
    output logic             mode_wr_ok
);
    logic               pll_off;
    logic [NUM_AUX-1:0] aux_en;
    logic               por_flag;

    ccsr_pll_bit u_pll (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_bit     (wr_data[PLL_POS]),
        .pll_stable (pll_stable),
        .pll_off    (pll_off)
    );

    ccsr_aux_gate #(.N(NUM_AUX)) u_aux (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_bits     (wr_data[AUX_BASE +: NUM_AUX]),
        .main_stable (main_stable),
        .en          (aux_en),
        .run         (aux_run)
    );

    ccsr_por_flag u_por (
        .clk     (clk),
        .rst_n   (rst_n),
        .por_det (por_det),
        .wr_en   (wr_en),
        .wr_bit  (wr_data[FLAG_POS]),
        .flag    (por_flag)
    );

    always_comb begin
        rd_data                      = '0;
        rd_data[PLL_POS]             = pll_off;
        rd_data[AUX_BASE +: NUM_AUX] = aux_en;
        rd_data[FLAG_POS]            = por_flag;
    end

    assign pll_pd     = pll_off;
    assign mode_wr_ok = ~sysclk_from_pll;

    a_r3_run_implies_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (aux_run & ~aux_en) == '0);
endmodule

// File: tb/sim_clk_ctl_status.sv
module sim_clk_ctl_status;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       pll_stable = 1'b0;
    logic       main_stable = 1'b0;
    logic       por_det = 1'b0;
    logic       sysclk_from_pll = 1'b0;
    logic [7:0] rd_data;
    logic       pll_pd;
    logic [1:0] aux_run;
    logic       mode_wr_ok;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    int m_pll = 1, m_en1 = 0, m_en2 = 0, m_por = 0, m_run1 = 0, m_run2 = 0;

    clk_ctl_status u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .pll_stable(pll_stable), .main_stable(main_stable), .por_det(por_det),
        .sysclk_from_pll(sysclk_from_pll), .rd_data(rd_data), .pll_pd(pll_pd),
        .aux_run(aux_run), .mode_wr_ok(mode_wr_ok)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural reference model
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_pll = 1; m_en1 = 0; m_en2 = 0; m_por = 0; m_run1 = 0; m_run2 = 0;
        end else begin
            if (wr_en) begin
                if (wr_data[0] == 1'b1) m_pll = 1;
                else if (pll_stable)    m_pll = 0;
                m_en1 = wr_data[1];
                m_en2 = wr_data[2];
                if (wr_data[3] == 1'b0) m_por = 0;
            end
            if (por_det) m_por = 1;
            m_run1 = (m_en1 && main_stable) ? 1 : 0;
            m_run2 = (m_en2 && main_stable) ? 1 : 0;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired: actual=%0d cycles expected<=100000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic compare_all();
        int exp_rd;
        exp_rd = m_pll | (m_en1 << 1) | (m_en2 << 2) | (m_por << 3);
        check("R9 rd_data layout", rd_data, exp_rd);
        check("R10 pll_pd", pll_pd, m_pll);
        check("R3 aux_run", aux_run, (m_run2 << 1) | m_run1);
        check("R8 mode_wr_ok", mode_wr_ok, sysclk_from_pll ? 0 : 1);
    endtask

    task automatic step(input logic w, input logic [7:0] d);
        wr_en = w;
        wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        por_det = 1'b0;
        compare_all();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset rd_data", rd_data, 8'h01);
        check("R1 reset pll_pd", pll_pd, 1);
        check("R1 reset aux_run", aux_run, 0);
        compare_all();

        // R2: clear blocked while PLL unstable
        step(1'b1, 8'h00);
        check("R2 clear ignored when unstable", pll_pd, 1);
        pll_stable = 1'b1;
        step(1'b1, 8'h00);
        check("R2 clear lands when stable", pll_pd, 0);
        pll_stable = 1'b0;
        step(1'b1, 8'h01);
        check("R2 set while unstable", pll_pd, 1);

        // R4/R3: enables and run gating
        main_stable = 1'b0;
        step(1'b1, 8'h07);
        check("R4 both enables", rd_data[2:1], 2'b11);
        check("R3 run held off unstable", aux_run, 2'b00);
        main_stable = 1'b1;
        step(1'b0, 8'h00);
        check("R3 run after stable edge", aux_run, 2'b11);
        step(1'b1, 8'h03);
        check("R4 aux2 disabled", rd_data[2:1], 2'b01);
        check("R3 only aux1 runs", aux_run, 2'b01);
        main_stable = 1'b0;
        step(1'b0, 8'h00);
        check("R3 run drops next edge", aux_run, 2'b00);
        main_stable = 1'b1;
        step(1'b1, 8'hF5);
        check("R9 upper bits read zero", rd_data[7:4], 0);
        check("R4 aux2 only", rd_data[2:1], 2'b10);

        // R5/R6/R7: power-on flag
        step(1'b1, 8'h0F);
        check("R6 sw cannot set flag", rd_data[3], 0);
        por_det = 1'b1;
        step(1'b0, 8'h00);
        check("R5 detect sets flag", rd_data[3], 1);
        step(1'b1, 8'h08);
        check("R6 write one keeps flag", rd_data[3], 1);
        step(1'b1, 8'h00);
        check("R6 write zero clears flag", rd_data[3], 0);
        por_det = 1'b1;
        step(1'b1, 8'h00);
        check("R7 detect beats clear", rd_data[3], 1);

        // R8: mode permit
        sysclk_from_pll = 1'b1;
        step(1'b0, 8'h00);
        check("R8 blocked from pll", mode_wr_ok, 0);
        sysclk_from_pll = 1'b0;
        step(1'b0, 8'h00);
        check("R8 allowed off pll", mode_wr_ok, 1);

        for (int i = 0; i < 24; i++) begin
            pll_stable  = i[0];
            main_stable = i[1];
            por_det     = (i % 5) == 0;
            step(i[2], 8'(i * 37));
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule